// File: doc/BRIEF.md
# SPI Memory-Access Transaction Decoder

This block is the device side of a serial host link. A host drives SCK, MOSI and an active-low chip select in SPI mode 0 (clock idles low, data sampled on the rising edge, changed on the falling edge) with 8-bit bytes sent MSB first. The decoder oversamples the three host lines in the system clock domain, assembles bytes and turns each chip-select frame into one of three things: a burst of memory writes, a burst of memory reads returned on MISO, or a host command reported on a one-cycle strobe.

The two top bits of the first byte of a frame give the frame type. Read and write frames carry a 22-bit byte address split across the low six bits of the first byte and the next two bytes. The address then steps by one per data byte for as long as chip select stays low, so multi-byte values placed least significant byte first land at ascending addresses. Reads need one dummy byte after the address, which gives the decoder time to fetch the first data byte from a simple synchronous memory port. One address holds a fixed, read-only identity byte served by the decoder itself.

Top module: `spi_mem_xact_decoder`

## Requirements
- R1: After reset MISO is low, `mem_req` and `hcmd_stb` are low and the decoder waits for the first byte of a frame.
- R2: A first byte with bits 7:6 = `10` starts a write; its bits 5:0 are address bits 21:16, the next two bytes are address bits 15:8 and 7:0, and every later complete byte is written with one `mem_req`/`mem_we` cycle to the current address, the address then rising by one.
- R3: A first byte with bits 7:6 = `00` starts a read; after the three address bytes one dummy byte follows, and each later byte slot returns, MSB first on MISO, the memory byte at the current address, ascending by one per slot; the memory port answers a `mem_req` with `mem_we` low by presenting `mem_rdata` on the next cycle.
- R4: The address wraps from 0x3FFFFF to 0x000000 within a burst.
- R5: A first byte with bits 7:6 = `01` is a host command; when the third byte of the frame completes and bytes two and three are both 0x00, `hcmd_stb` pulses for one cycle with `hcmd_code` equal to the whole first byte.
- R6: A host command frame whose second or third byte is non-zero, or that ends before its third byte completes, produces no strobe; bytes after the third are ignored.
- R7: A read of address `ID_ADDR` (default 0x0C0000) returns `ID_VALUE` (0x7C) without a memory access, and a write to that address causes no memory write.
- R8: Chip select rising in the middle of a byte ends the frame; the partial byte is never written, while bytes completed before it stay written.
- R9: A first byte with bits 7:6 = `11` makes the decoder ignore the whole frame: no memory access and no strobe.
- R10: MISO is low while chip select is high and changes only after SCK falling edges; each SCK phase must last at least 4 system clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck | input | 1 | Host serial clock, mode 0 |
| csn | input | 1 | Active-low chip select framing a transaction |
| mosi | input | 1 | Host-to-device serial data |
| miso | output | 1 | Device-to-host serial data |
| mem_req | output | 1 | One-cycle memory access request |
| mem_we | output | 1 | Access is a write when high |
| mem_addr | output | ADDR_W | Byte address of the access |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid the cycle after a read request |
| hcmd_stb | output | 1 | One-cycle host command strobe |
| hcmd_code | output | 8 | Host command code, valid with the strobe |

## Verification
Write bursts with a high address page and a distinct byte per slot show that address assembly, bit order and the per-byte increment are right, and reading the same range back shows the dummy-byte alignment of MISO. A burst across the top of the address space separates true 22-bit wrapping from carry into unused bits. Host commands are sent well formed, with a non-zero trailing byte and truncated, which tells the zero check and the completion rule apart. Frames aimed at the identity address, frames cut mid-byte and frames with the reserved prefix each leave memory and the strobe log untouched where a faulty decoder would disturb them.

// File: rtl/spi_xact_pkg.sv
package spi_xact_pkg;

  localparam int BYTE_W = 8;
  localparam int BIT_CNT_W = $clog2(BYTE_W);

  // Frame kind taken from bits 7:6 of the first byte.
  typedef enum logic [1:0] {
    XK_READ    = 2'b00,
    XK_HOSTCMD = 2'b01,
    XK_WRITE   = 2'b10,
    XK_RSVD    = 2'b11
  } xact_kind_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR_MID,
    ST_ADDR_LO,
    ST_DUMMY,
    ST_RDATA,
    ST_WDATA,
    ST_CMD_A,
    ST_CMD_B,
    ST_DISCARD
  } xact_state_e;

  function automatic xact_kind_e decode_kind(input logic [BYTE_W-1:0] first);
    return xact_kind_e'(first[BYTE_W-1 -: 2]);
  endfunction

  // A host command is accepted only with both trailing bytes at zero.
  function automatic logic cmd_accept(input logic prev_zero,
                                      input logic [BYTE_W-1:0] last);
    return prev_zero && (last == '0);
  endfunction

endpackage

// File: rtl/spi_edge_sync.sv
module spi_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck,
  input  logic csn,
  input  logic mosi,
  output logic sck_rise,
  output logic sck_fall,
  output logic cs_active,
  output logic mosi_s
);
  localparam int NSIG = 3;
  // Reset level per line, ordered {mosi, csn, sck}.
  localparam logic [NSIG-1:0] IDLE_LVL = 3'b010;

  logic [NSIG-1:0] raw;
  logic [NSIG-1:0] synced;
  logic            sck_d;

  assign raw = {mosi, csn, sck};

  for (genvar g = 0; g < NSIG; g++) begin : g_sig
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{IDLE_LVL[g]}};
      else        chain <= {chain[STAGES-2:0], raw[g]};
    end
    assign synced[g] = chain[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sck_d <= 1'b0;
    else        sck_d <= synced[0];
  end

  assign cs_active = ~synced[1];
  assign mosi_s    = synced[2];
  assign sck_rise  = synced[0] & ~sck_d & cs_active;
  assign sck_fall  = ~synced[0] & sck_d & cs_active;
endmodule

// File: rtl/spi_byte_shifter.sv
module spi_byte_shifter
  import spi_xact_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_active,
  input  logic              sck_rise,
  input  logic              sck_fall,
  input  logic              mosi_s,
  input  logic [BYTE_W-1:0] tx_byte,
  output logic              byte_done,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              miso
);
  localparam logic [BIT_CNT_W-1:0] LAST_BIT = BIT_CNT_W'(BYTE_W - 1);

  logic [BIT_CNT_W-1:0] bit_q;
  logic [BYTE_W-2:0]    rx_q;
  logic [BYTE_W-1:0]    tx_q;

  assign byte_done = sck_rise && (bit_q == LAST_BIT);
  assign rx_byte   = {rx_q, mosi_s};
  assign miso      = tx_q[BYTE_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_q <= '0;
      rx_q  <= '0;
      tx_q  <= '0;
    end else if (!cs_active) begin
      bit_q <= '0;
      rx_q  <= '0;
      tx_q  <= '0;
    end else begin
      if (sck_rise) begin
        rx_q  <= {rx_q[BYTE_W-3:0], mosi_s};
        bit_q <= bit_q + 1'b1;
      end
      if (sck_fall) begin
        // At a byte boundary the next outgoing byte is loaded, else shift.
        if (bit_q == '0) tx_q <= tx_byte;
        else             tx_q <= {tx_q[BYTE_W-2:0], 1'b0};
      end
    end
  end
endmodule

// File: rtl/xact_engine.sv
module xact_engine
  import spi_xact_pkg::*;
#(
  parameter int                ADDR_W   = 22,
  parameter logic [ADDR_W-1:0] ID_ADDR  = 22'h0C0000,
  parameter logic [7:0]        ID_VALUE = 8'h7C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_active,
  input  logic              byte_done,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic [BYTE_W-1:0] mem_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [BYTE_W-1:0] mem_wdata,
  output logic              hcmd_stb,
  output logic [BYTE_W-1:0] hcmd_code,
  output logic [BYTE_W-1:0] tx_byte,
  output xact_state_e       state_o
);
  localparam int HI_W = ADDR_W - 16;

  function automatic logic [ADDR_W-1:0] addr_step(input logic [ADDR_W-1:0] a);
    return a + ADDR_W'(1);
  endfunction

  xact_state_e       state_q;
  logic [ADDR_W-1:0] addr_q;
  logic [BYTE_W-1:0] code_q;
  logic              is_write_q;
  logic              cmd_zero_q;
  logic              fetch_q;
  logic              fetch_id_q;
  logic [BYTE_W-1:0] tx_q;
  logic              stb_q;

  logic rd_fire, wr_fire, id_hit;

  assign id_hit  = (addr_q == ID_ADDR);
  assign rd_fire = byte_done && (state_q == ST_DUMMY || state_q == ST_RDATA);
  assign wr_fire = byte_done && (state_q == ST_WDATA);

  assign mem_req   = (rd_fire || wr_fire) && !id_hit;
  assign mem_we    = wr_fire && !id_hit;
  assign mem_addr  = addr_q;
  assign mem_wdata = rx_byte;
  assign hcmd_stb  = stb_q;
  assign hcmd_code = code_q;
  assign tx_byte   = tx_q;
  assign state_o   = state_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      addr_q     <= '0;
      code_q     <= '0;
      is_write_q <= 1'b0;
      cmd_zero_q <= 1'b0;
    end else if (!cs_active) begin
      state_q <= ST_IDLE;
    end else if (byte_done) begin
      case (state_q)
        ST_IDLE: begin
          case (decode_kind(rx_byte))
            XK_READ, XK_WRITE: begin
              addr_q     <= {rx_byte[HI_W-1:0], 16'h0000};
              is_write_q <= (decode_kind(rx_byte) == XK_WRITE);
              state_q    <= ST_ADDR_MID;
            end
            XK_HOSTCMD: begin
              code_q  <= rx_byte;
              state_q <= ST_CMD_A;
            end
            default: state_q <= ST_DISCARD;
          endcase
        end
        ST_ADDR_MID: begin
          addr_q[15:8] <= rx_byte;
          state_q      <= ST_ADDR_LO;
        end
        ST_ADDR_LO: begin
          addr_q[7:0] <= rx_byte;
          state_q     <= is_write_q ? ST_WDATA : ST_DUMMY;
        end
        ST_DUMMY: begin
          addr_q  <= addr_step(addr_q);
          state_q <= ST_RDATA;
        end
        ST_RDATA, ST_WDATA: addr_q <= addr_step(addr_q);
        ST_CMD_A: begin
          cmd_zero_q <= (rx_byte == '0);
          state_q    <= ST_CMD_B;
        end
        ST_CMD_B: state_q <= ST_DISCARD;
        default:  state_q <= ST_DISCARD;
      endcase
    end
  end

  // Strobe one cycle after the third command byte completes.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stb_q <= 1'b0;
    else        stb_q <= cs_active && byte_done && (state_q == ST_CMD_B) &&
                         cmd_accept(cmd_zero_q, rx_byte);
  end

  // Read data path: request, then capture one cycle later.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fetch_q    <= 1'b0;
      fetch_id_q <= 1'b0;
      tx_q       <= '0;
    end else begin
      fetch_q    <= cs_active && rd_fire;
      fetch_id_q <= id_hit;
      if (!cs_active)   tx_q <= '0;
      else if (fetch_q) tx_q <= fetch_id_q ? ID_VALUE : mem_rdata;
    end
  end
endmodule

// File: rtl/spi_mem_xact_decoder.sv
module spi_mem_xact_decoder
  import spi_xact_pkg::*;
#(
  parameter int                ADDR_W      = 22,
  parameter int                SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] ID_ADDR     = 22'h0C0000,
  parameter logic [7:0]        ID_VALUE    = 8'h7C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck,
  input  logic              csn,
  input  logic              mosi,
  output logic              miso,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  input  logic [7:0]        mem_rdata,
  output logic              hcmd_stb,
  output logic [7:0]        hcmd_code
);
  logic              sck_rise, sck_fall, cs_active, mosi_s;
  logic              byte_done;
  logic [BYTE_W-1:0] rx_byte, tx_byte;
  xact_state_e       eng_state;

  spi_edge_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .sck(sck), .csn(csn), .mosi(mosi),
    .sck_rise(sck_rise), .sck_fall(sck_fall),
    .cs_active(cs_active), .mosi_s(mosi_s)
  );

  spi_byte_shifter shift_i (
    .clk(clk), .rst_n(rst_n), .cs_active(cs_active),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .mosi_s(mosi_s),
    .tx_byte(tx_byte), .byte_done(byte_done), .rx_byte(rx_byte),
    .miso(miso)
  );

  xact_engine #(.ADDR_W(ADDR_W), .ID_ADDR(ID_ADDR), .ID_VALUE(ID_VALUE)) eng_i (
    .clk(clk), .rst_n(rst_n), .cs_active(cs_active),
    .byte_done(byte_done), .rx_byte(rx_byte), .mem_rdata(mem_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .hcmd_stb(hcmd_stb), .hcmd_code(hcmd_code),
    .tx_byte(tx_byte), .state_o(eng_state)
  );
endmodule

// File: rtl/xact_checker.sv
module xact_checker
  import spi_xact_pkg::*;
#(
  parameter int                ADDR_W  = 22,
  parameter logic [ADDR_W-1:0] ID_ADDR = 22'h0C0000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_active,
  input logic              byte_done,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              hcmd_stb,
  input logic              miso,
  input xact_state_e       eng_state
);
  // R8: memory is touched only on a completed byte
  a_r8_req_on_whole_byte: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> byte_done);

  // R5: the command strobe lasts one cycle
  a_r5_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    hcmd_stb |=> !hcmd_stb);

  // R5: a strobe never coincides with a memory access
  a_r5_strobe_excl_mem: assert property (@(posedge clk) disable iff (!rst_n)
    hcmd_stb |-> !mem_req);

  // R7: the identity address is never written
  a_r7_id_not_written: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> (mem_addr != ID_ADDR));

  // R1: deselect returns the engine to waiting for a first byte
  a_r1_idle_when_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_active |=> (eng_state == ST_IDLE));

  // R10: MISO is quiet while deselected
  a_r10_miso_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_active |=> !miso);

  // R9: a reserved frame never reaches memory
  a_r9_discard_no_req: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_state == ST_DISCARD) |-> !mem_req);
endmodule

bind spi_mem_xact_decoder xact_checker #(.ADDR_W(ADDR_W), .ID_ADDR(ID_ADDR)) chk_i (
  .clk(clk), .rst_n(rst_n), .cs_active(cs_active), .byte_done(byte_done),
  .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
  .hcmd_stb(hcmd_stb), .miso(miso), .eng_state(eng_state)
);

// File: tb/spi_mem_xact_decoder_tb_top.sv
`timescale 1ns/1ps
module spi_mem_xact_decoder_tb_top;
  localparam int HALF = 8;
  localparam logic [21:0] ID_A = 22'h0C0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0, csn = 1'b1, mosi = 1'b0;
  logic miso, mem_req, mem_we, hcmd_stb;
  logic [21:0] mem_addr;
  logic [7:0] mem_wdata, mem_rdata, hcmd_code;

  int errors = 0, checks = 0;
  logic [7:0] mem [0:255];
  logic [21:0] wlog_a [0:31];
  logic [7:0]  wlog_d [0:31];
  int wcnt = 0;
  logic [7:0] clog [0:15];
  int ccnt = 0;
  logic [7:0] rd_buf [0:7];
  logic [7:0] wr_buf [0:7];
  logic [7:0] junk;

  always #2 clk = ~clk;

  spi_mem_xact_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .sck(sck), .csn(csn), .mosi(mosi), .miso(miso),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .hcmd_stb(hcmd_stb), .hcmd_code(hcmd_code)
  );

  initial for (int i = 0; i < 256; i++) mem[i] = 8'(i * 3 + 1);

  always @(posedge clk) begin
    if (mem_req) begin
      if (mem_we) begin
        mem[mem_addr[7:0]] <= mem_wdata;
        if (wcnt < 32) begin wlog_a[wcnt] = mem_addr; wlog_d[wcnt] = mem_wdata; end
        wcnt++;
      end else mem_rdata <= mem[mem_addr[7:0]];
    end
    if (hcmd_stb) begin
      if (ccnt < 16) clog[ccnt] = hcmd_code;
      ccnt++;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      mosi = tx[i];
      wait_clk(HALF);
      sck = 1'b1;
      rx[i] = miso;
      wait_clk(HALF);
      sck = 1'b0;
    end
  endtask

  task automatic cs_begin();
    csn = 1'b0;
    wait_clk(HALF);
  endtask

  task automatic cs_end();
    wait_clk(HALF);
    csn = 1'b1;
    wait_clk(2 * HALF);
  endtask

  task automatic do_write(input logic [21:0] a, input int n);
    cs_begin();
    xfer({2'b10, a[21:16]}, junk);
    xfer(a[15:8], junk);
    xfer(a[7:0], junk);
    for (int i = 0; i < n; i++) xfer(wr_buf[i], junk);
    cs_end();
  endtask

  task automatic do_read(input logic [21:0] a, input int n);
    cs_begin();
    xfer({2'b00, a[21:16]}, junk);
    xfer(a[15:8], junk);
    xfer(a[7:0], junk);
    xfer(8'h00, junk);
    for (int i = 0; i < n; i++) xfer(8'hFF, rd_buf[i]);
    cs_end();
  endtask

  task automatic send3(input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] b2);
    cs_begin();
    xfer(b0, junk); xfer(b1, junk); xfer(b2, junk);
    cs_end();
  endtask

  task automatic t_reset();
    check(miso == 1'b0, "R1 miso", miso, 0);
    check(mem_req == 1'b0, "R1 mem_req", mem_req, 0);
    check(hcmd_stb == 1'b0, "R1 hcmd_stb", hcmd_stb, 0);
  endtask

  task automatic t_write_burst();
    int w0 = wcnt;
    wr_buf[0] = 8'hA1; wr_buf[1] = 8'hB2; wr_buf[2] = 8'hC3;
    do_write(22'h3A0010, 3);
    check(wcnt - w0 == 3, "R2 write count", wcnt - w0, 3);
    for (int i = 0; i < 3; i++) begin
      check(wlog_a[w0+i] == 22'h3A0010 + 22'(i), "R2 write addr", wlog_a[w0+i], 22'h3A0010 + i);
      check(wlog_d[w0+i] == wr_buf[i], "R2 write data", wlog_d[w0+i], wr_buf[i]);
    end
  endtask

  task automatic t_read_burst();
    do_read(22'h3A0010, 3);
    check(rd_buf[0] == 8'hA1, "R3 read byte0", rd_buf[0], 8'hA1);
    check(rd_buf[1] == 8'hB2, "R3 read byte1", rd_buf[1], 8'hB2);
    check(rd_buf[2] == 8'hC3, "R3 read byte2", rd_buf[2], 8'hC3);
    do_read(22'h000040, 2);
    check(rd_buf[0] == 8'(8'h40 * 3 + 1), "R3 read init0", rd_buf[0], 8'(8'h40 * 3 + 1));
    check(rd_buf[1] == 8'(8'h41 * 3 + 1), "R3 read init1", rd_buf[1], 8'(8'h41 * 3 + 1));
  endtask

  task automatic t_wrap();
    int w0 = wcnt;
    wr_buf[0] = 8'h5E; wr_buf[1] = 8'h6F;
    do_write(22'h3FFFFF, 2);
    check(wlog_a[w0] == 22'h3FFFFF, "R4 addr top", wlog_a[w0], 22'h3FFFFF);
    check(wlog_a[w0+1] == 22'h000000, "R4 addr wrap", wlog_a[w0+1], 0);
    do_read(22'h3FFFFF, 2);
    check(rd_buf[1] == 8'h6F, "R4 read wrap", rd_buf[1], 8'h6F);
  endtask

  task automatic t_hostcmd();
    int c0 = ccnt;
    send3(8'h44, 8'h00, 8'h00);
    check(ccnt - c0 == 1, "R5 strobe count", ccnt - c0, 1);
    check(clog[c0] == 8'h44, "R5 code", clog[c0], 8'h44);
    send3(8'h68, 8'h00, 8'h00);
    check(clog[c0+1] == 8'h68, "R5 code2", clog[c0+1], 8'h68);
  endtask

  task automatic t_hostcmd_bad();
    int c0 = ccnt;
    int w0 = wcnt;
    send3(8'h41, 8'h00, 8'h05);
    check(ccnt == c0, "R6 nonzero tail", ccnt - c0, 0);
    send3(8'h42, 8'h07, 8'h00);
    check(ccnt == c0, "R6 nonzero second", ccnt - c0, 0);
    cs_begin(); xfer(8'h44, junk); xfer(8'h00, junk); cs_end();
    check(ccnt == c0, "R6 truncated", ccnt - c0, 0);
    cs_begin();
    xfer(8'h45, junk); xfer(8'h00, junk); xfer(8'h00, junk);
    xfer(8'h00, junk); xfer(8'h00, junk);
    cs_end();
    check(ccnt - c0 == 1, "R6 extra bytes one strobe", ccnt - c0, 1);
    check(wcnt == w0, "R6 no memory write", wcnt - w0, 0);
  endtask

  task automatic t_identity();
    int w0 = wcnt;
    do_read(ID_A, 1);
    check(rd_buf[0] == 8'h7C, "R7 id read", rd_buf[0], 8'h7C);
    wr_buf[0] = 8'h00;
    do_write(ID_A, 1);
    check(wcnt == w0, "R7 id write suppressed", wcnt - w0, 0);
    do_read(ID_A, 1);
    check(rd_buf[0] == 8'h7C, "R7 id after write", rd_buf[0], 8'h7C);
  endtask

  task automatic t_abort();
    int w0 = wcnt;
    cs_begin();
    xfer(8'h80, junk); xfer(8'h00, junk); xfer(8'h20, junk);
    xfer(8'h11, junk);
    for (int i = 7; i >= 4; i--) begin
      mosi = 1'b1; wait_clk(HALF); sck = 1'b1; wait_clk(HALF); sck = 1'b0;
    end
    cs_end();
    check(wcnt - w0 == 1, "R8 abort write count", wcnt - w0, 1);
    check(mem[8'h20] == 8'h11, "R8 whole byte kept", mem[8'h20], 8'h11);
    check(mem[8'h21] == 8'h64, "R8 partial not written", mem[8'h21], 8'h64);
  endtask

  task automatic t_reserved();
    int w0 = wcnt;
    int c0 = ccnt;
    cs_begin();
    xfer(8'hC0, junk); xfer(8'h00, junk); xfer(8'h20, junk);
    xfer(8'h99, junk); xfer(8'h00, junk);
    cs_end();
    check(wcnt == w0, "R9 no write", wcnt - w0, 0);
    check(ccnt == c0, "R9 no strobe", ccnt - c0, 0);
    check(mem[8'h20] == 8'h11, "R9 memory intact", mem[8'h20], 8'h11);
  endtask

  task automatic t_miso_idle();
    mem[8'h30] = 8'hFF;
    do_read(22'h000030, 1);
    check(rd_buf[0] == 8'hFF, "R10 read ones", rd_buf[0], 8'hFF);
    check(miso == 1'b0, "R10 miso low deselected", miso, 0);
  endtask

  initial begin
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(5);
    t_reset();
    t_write_burst();
    t_read_burst();
    t_wrap();
    t_hostcmd();
    t_hostcmd_bad();
    t_identity();
    t_abort();
    t_reserved();
    t_miso_idle();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule